// File: doc/BRIEF.md
# Reference-Based Frequency Lock Checker

This block decides whether a recovered data-rate clock runs at the frequency that a reference clock and two power-of-two dividers imply. The lock condition is that the data rate divided by 2^n equals the reference rate divided by 2^k. The exponent n is the ratio code in the control byte, and k is the reference octave selector in the same byte. The design times a measurement window of 2^WIN_LOG2 divided reference edges. Over that window it counts data-clock cycles in the data domain. It then hands the raw count back to the reference domain with a toggle handshake and scales the count by the ratio exponent. The scaled count is compared against 2^WIN_LOG2 within ±TOL.

An external frequency loop uses the two direction outputs to steer its oscillator toward the target. The lock output tells the rest of the chip that the recovered clock can be trusted. A lock needs two passing windows in a row, and one failing window removes it. Changing the control byte, or leaving lock-to-reference mode, restarts the measurement. The first result after a restart is discarded because it spans a partial window.

Top module: `freq_lock_checker`

## Requirements
- R1: While `rst` is high and in the cycle after it, `locked`, `freq_high`, `freq_low` and `code_err` are all low.
- R2: Measurement runs only when `enable` is high, `ctrl[0]` (lock to reference) is 1 and `ctrl[1]` (rate readback) is 0. In any other case all four outputs go low one reference cycle later.
- R3: When the data clock runs at exactly ref * 2^ctrl[5:2] / 2^ctrl[7:6], `locked` is high once three windows after a restart have completed.
- R4: The first window result after a restart is discarded. `locked` rises only after two consecutive passing windows, so it is still low 2.5 windows after the restart.
- R5: A single failing window drops `locked`. While `locked` is high, `freq_high` and `freq_low` are low.
- R6: After each window, `freq_high` is set if the scaled count exceeds 2^WIN_LOG2 + TOL, and `freq_low` is set if it is below 2^WIN_LOG2 − TOL. The two are never high together.
- R7: A ratio code in `ctrl[5:2]` from 9 to 15, with the mode bits selecting lock to reference and `enable` high, sets `code_err` and holds `locked` low starting the next reference cycle.
- R8: The reference octave selector `ctrl[7:6]` = k lengthens the window to 2^(WIN_LOG2+k) reference cycles. With k=1, a data clock at half the reference rate locks.
- R9: A ratio code n from 0 to 8 scales the data count by 2^−n. The codes 2, 5 and 8 each lock when the data clock runs at 2^(n−k) times the reference rate.
- R10: Setting both `ctrl[0]` and `ctrl[1]` is treated as inactive and clears a held lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all control and outputs belong to this domain |
| clk_data | input | 1 | Recovered data-rate clock being checked |
| rst | input | 1 | Synchronous active-high reset (reference domain, re-synchronised for data side) |
| enable | input | 1 | Enables the checker |
| ctrl | input | 8 | [7:6] reference octave k, [5:2] ratio exponent n, [1] rate readback mode, [0] lock-to-reference mode |
| locked | output | 1 | Frequency lock indication |
| freq_high | output | 1 | Last window: scaled data count above tolerance band |
| freq_low | output | 1 | Last window: scaled data count below tolerance band |
| code_err | output | 1 | Ratio exponent code above 8 in lock-to-reference mode |

## Verification
The bench builds the block with WIN_LOG2 = 4 and TOL = 1. A window is then only 16 divided reference edges, so even octave 3 with ratio code 8 locks within a few hundred reference cycles, and a 25 % rate error falls far outside the ±1 band. The data clock period is changed at run time, which lets one run cover matched rates, fast and slow offsets, every octave/ratio combination used by the requirements, and the loss of lock inside a held lock.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;
  localparam int OCT_W    = 2;
  localparam int EXP_W    = 4;
  localparam int EXP_MAX  = 8;

  typedef struct packed {
    logic [OCT_W-1:0] octave;
    logic [EXP_W-1:0] rexp;
    logic             rdbk_mode;
    logic             lock_mode;
  } cfg_t;
endpackage

// File: rtl/flc_ref_timer.sv
`timescale 1ns/1ps
module flc_ref_timer #(
  parameter int WIN_LOG2 = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      restart,
  input  logic [flc_pkg::OCT_W-1:0] octave,
  output logic                      req_tgl
);
  localparam int TW = WIN_LOG2 + (1 << flc_pkg::OCT_W);

  logic [TW-1:0] tick;
  logic [TW-1:0] last_tick;

  assign last_tick = (TW'(1) << (WIN_LOG2 + int'(octave))) - TW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      req_tgl <= 1'b0;
    end else if (restart) begin
      tick    <= '0;
    end else if (tick == last_tick) begin
      tick    <= '0;
      req_tgl <= ~req_tgl;
    end else begin
      tick    <= tick + TW'(1);
    end
  end
endmodule

// File: rtl/flc_data_counter.sv
`timescale 1ns/1ps
module flc_data_counter #(
  parameter int CW = 22
) (
  input  logic          clk_data,
  input  logic          rst,
  input  logic          req_tgl,
  output logic          ack_tgl,
  output logic [CW-1:0] held_cnt
);
  logic          rst_m, rst_d;
  logic [2:0]    req_sync;
  logic [CW-1:0] run_cnt;
  logic          req_edge;

  always_ff @(posedge clk_data) begin
    rst_m <= rst;
    rst_d <= rst_m;
  end

  assign req_edge = req_sync[2] ^ req_sync[1];

  always_ff @(posedge clk_data) begin
    if (rst_d) begin
      req_sync <= '0;
      run_cnt  <= '0;
      held_cnt <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      req_sync <= {req_sync[1:0], req_tgl};
      if (req_edge) begin
        held_cnt <= run_cnt;
        run_cnt  <= CW'(1);
        ack_tgl  <= ~ack_tgl;
      end else if (run_cnt != '1) begin
        run_cnt  <= run_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/flc_judge.sv
`timescale 1ns/1ps
module flc_judge #(
  parameter int WIN_LOG2 = 12,
  parameter int TOL      = 1,
  parameter int CW       = 22
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      restart,
  input  logic                      bad_code,
  input  logic [flc_pkg::EXP_W-1:0] rexp,
  input  logic                      ack_tgl,
  input  logic [CW-1:0]             held_cnt,
  output logic                      res_vld,
  output logic                      locked,
  output logic                      freq_high,
  output logic                      freq_low,
  output logic                      code_err
);
  localparam logic [CW-1:0] TARGET = CW'(1) << WIN_LOG2;
  localparam logic [CW-1:0] UPPER  = TARGET + CW'(TOL);
  localparam logic [CW-1:0] LOWER  = TARGET - CW'(TOL);

  logic [2:0]    ack_sync;
  logic          ack_edge;
  logic          primed;
  logic          pass_prev;
  logic [CW-1:0] scaled;
  logic          over, under;

  assign ack_edge = ack_sync[2] ^ ack_sync[1];
  assign scaled   = held_cnt >> rexp;
  assign over     = scaled > UPPER;
  assign under    = scaled < LOWER;
  assign res_vld  = ack_edge & primed & ~restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_sync <= '0;
      code_err <= 1'b0;
    end else begin
      ack_sync <= {ack_sync[1:0], ack_tgl};
      code_err <= bad_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      primed    <= 1'b0;
      pass_prev <= 1'b0;
      locked    <= 1'b0;
      freq_high <= 1'b0;
      freq_low  <= 1'b0;
    end else if (ack_edge) begin
      if (!primed) begin
        primed <= 1'b1;
      end else begin
        freq_high <= over;
        freq_low  <= under;
        if (!over && !under) begin
          pass_prev <= 1'b1;
          locked    <= pass_prev;
        end else begin
          pass_prev <= 1'b0;
          locked    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/freq_lock_checker.sv
`timescale 1ns/1ps
module freq_lock_checker #(
  parameter int WIN_LOG2 = 12,
  parameter int TOL      = 1
) (
  input  logic       clk_ref,
  input  logic       clk_data,
  input  logic       rst,
  input  logic       enable,
  input  logic [7:0] ctrl,
  output logic       locked,
  output logic       freq_high,
  output logic       freq_low,
  output logic       code_err
);
  import flc_pkg::*;
  localparam int CW = WIN_LOG2 + EXP_MAX + 2;

  cfg_t          cfg;
  logic [7:0]    ctrl_q;
  logic          mode_ok, code_ok, restart;
  logic          req_tgl, ack_tgl, res_vld;
  logic [CW-1:0] held_cnt;

  assign cfg     = cfg_t'(ctrl);
  assign mode_ok = enable & cfg.lock_mode & ~cfg.rdbk_mode;
  assign code_ok = cfg.rexp <= EXP_W'(EXP_MAX);
  assign restart = ~(mode_ok & code_ok) | (ctrl != ctrl_q);

  always_ff @(posedge clk_ref) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl;
  end

  flc_ref_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk(clk_ref), .rst(rst), .restart(restart),
    .octave(cfg.octave), .req_tgl(req_tgl)
  );

  flc_data_counter #(.CW(CW)) u_dcnt (
    .clk_data(clk_data), .rst(rst), .req_tgl(req_tgl),
    .ack_tgl(ack_tgl), .held_cnt(held_cnt)
  );

  flc_judge #(.WIN_LOG2(WIN_LOG2), .TOL(TOL), .CW(CW)) u_judge (
    .clk(clk_ref), .rst(rst), .restart(restart),
    .bad_code(mode_ok & ~code_ok), .rexp(cfg.rexp),
    .ack_tgl(ack_tgl), .held_cnt(held_cnt), .res_vld(res_vld),
    .locked(locked), .freq_high(freq_high), .freq_low(freq_low),
    .code_err(code_err)
  );
endmodule

// File: rtl/flc_checker.sv
`timescale 1ns/1ps
module flc_checker (
  input logic       clk_ref,
  input logic       rst,
  input logic       enable,
  input logic [7:0] ctrl,
  input logic       locked,
  input logic       freq_high,
  input logic       freq_low,
  input logic       code_err,
  input logic       res_vld
);
  assert_reset_clear_R1: assert property (@(posedge clk_ref)
    rst |=> (!locked && !freq_high && !freq_low && !code_err));

  assert_idle_clear_R2: assert property (@(posedge clk_ref) disable iff (rst)
    !(enable && ctrl[0] && !ctrl[1]) |=> (!locked && !freq_high && !freq_low));

  assert_lock_after_result_R4: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(locked) |-> $past(res_vld));

  assert_lock_no_dir_R5: assert property (@(posedge clk_ref) disable iff (rst)
    locked |-> (!freq_high && !freq_low));

  assert_dir_exclusive_R6: assert property (@(posedge clk_ref) disable iff (rst)
    !(freq_high && freq_low));

  assert_bad_code_R7: assert property (@(posedge clk_ref) disable iff (rst)
    (enable && ctrl[0] && !ctrl[1] && ctrl[5:2] > 4'd8) |=> (code_err && !locked));
endmodule

bind freq_lock_checker flc_checker u_chk (
  .clk_ref(clk_ref), .rst(rst), .enable(enable), .ctrl(ctrl),
  .locked(locked), .freq_high(freq_high), .freq_low(freq_low),
  .code_err(code_err), .res_vld(res_vld)
);

// File: tb/freq_lock_checker_test.sv
`timescale 1ns/1ps
module freq_lock_checker_test;
  localparam int WL = 4;

  typedef struct {
    logic  lk, hi, lo, er;
    bit    lock_only;
    string tag;
  } exp_t;

  logic       clk_ref = 1'b0, clk_data = 1'b0, rst = 1'b1, enable = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic       locked, freq_high, freq_low, code_err;
  real        dhalf = 2.0;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  exp_t       sb[$];

  freq_lock_checker #(.WIN_LOG2(WL), .TOL(1)) uut (
    .clk_ref(clk_ref), .clk_data(clk_data), .rst(rst), .enable(enable),
    .ctrl(ctrl), .locked(locked), .freq_high(freq_high), .freq_low(freq_low),
    .code_err(code_err)
  );

  always #2 clk_ref = ~clk_ref;
  initial forever #(dhalf) clk_data = ~clk_data;

  task automatic waitc(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic setup(input logic e, input logic [7:0] c, input real h);
    @(negedge clk_ref);
    enable = e; ctrl = c; dhalf = h;
  endtask

  task automatic expect_out(input logic lk, hi, lo, er, input bit lonly, input string tag);
    exp_t it;
    it.lk = lk; it.hi = hi; it.lo = lo; it.er = er; it.lock_only = lonly; it.tag = tag;
    sb.push_back(it);
    while (sb.size() != 0) @(negedge clk_ref);
  endtask

  // monitor: pops expected items and compares against outputs
  initial forever begin
    @(negedge clk_ref);
    if (sb.size() != 0) begin
      exp_t it;
      it = sb.pop_front();
      n_chk++;
      if (it.lock_only ? (locked !== it.lk)
          : ({locked, freq_high, freq_low, code_err} !== {it.lk, it.hi, it.lo, it.er})) begin
        n_fail++;
        $display("FAIL %s: got lk/hi/lo/err=%b%b%b%b expected %b%b%b%b",
                 it.tag, locked, freq_high, freq_low, code_err, it.lk, it.hi, it.lo, it.er);
      end
    end
  end

  // watchdog
  always @(posedge clk_ref) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    waitc(20);
    rst = 1'b0;
    waitc(2);
    expect_out(0, 0, 0, 0, 0, "R1 reset state");

    setup(1, 8'h01, 2.0);                       // octave 0, exp 0, equal rates
    waitc(40);
    expect_out(0, 0, 0, 0, 1, "R4 no lock at 2.5 windows");
    waitc(56);
    expect_out(1, 0, 0, 0, 0, "R3 matched rates lock");

    dhalf = 1.6;                                 // data 25% fast
    waitc(48);
    expect_out(0, 1, 0, 0, 0, "R5 R6 fast drops lock");
    dhalf = 2.6;                                 // data slow
    waitc(48);
    expect_out(0, 0, 1, 0, 0, "R6 slow flagged low");

    setup(1, 8'h41, 4.0);                        // octave 1: half rate
    waitc(6 * 32);
    expect_out(1, 0, 0, 0, 0, "R8 octave 1 lock");

    setup(1, 8'h09, 0.5);                        // exp 2: 4x rate
    waitc(96);
    expect_out(1, 0, 0, 0, 0, "R9 exp 2 lock");

    setup(1, 8'hD5, 0.5);                        // octave 3 exp 5: 4x rate
    waitc(6 * 128);
    expect_out(1, 0, 0, 0, 0, "R9 exp 5 octave 3 lock");

    setup(1, 8'hE1, 0.0625);                     // octave 3 exp 8: 32x rate
    waitc(6 * 128);
    expect_out(1, 0, 0, 0, 0, "R9 exp 8 boundary lock");

    setup(1, 8'h25, 2.0);                        // exp code 9 invalid
    waitc(4);
    expect_out(0, 0, 0, 1, 0, "R7 invalid exponent code");

    setup(1, 8'h01, 2.0);
    waitc(96);
    expect_out(1, 0, 0, 0, 0, "R3 relock after invalid code");
    setup(1, 8'h03, 2.0);                        // both mode bits
    waitc(3);
    expect_out(0, 0, 0, 0, 0, "R10 both mode bits inactive");

    setup(1, 8'h01, 2.0);
    waitc(96);
    expect_out(1, 0, 0, 0, 0, "R3 relock before disable");
    setup(0, 8'h01, 2.0);
    waitc(3);
    expect_out(0, 0, 0, 0, 0, "R2 disable clears outputs");

    setup(1, 8'h00, 2.0);                        // lock mode bit clear
    waitc(96);
    expect_out(0, 0, 0, 0, 0, "R2 lock mode off never locks");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule